// File: doc/BRIEF.md
# Processor Debug Entry Controller

This block decides the cycle in which a processor core stops and enters debug mode. It watches the instruction pipeline through a few event lines: an instruction arriving in the instruction latch, an instruction retiring, an instruction aborting, a breakpoint instruction retiring, and a flag for a low-power state. A host request, a breakpoint with force-debug enabled, a trace countdown reaching zero, or a request held at reset release can each cause debug entry. Each source has its own halt point.

The controller is a six-state machine.

| State | Meaning |
|---|---|
| `ST_INIT` | The first cycle after reset. |
| `ST_RUN` | Normal execution. |
| `ST_ARM` | A request is pending and the controller waits for the next latch arrival. |
| `ST_BOOT_VEC` | Boot halt: waiting for the vector fetch to reach the latch. |
| `ST_BOOT_INS` | Boot halt: waiting for the first handler instruction to reach the latch. |
| `ST_HALT` | Debug mode. |

Its transitions are:

- INIT→BOOT_VEC when a boot halt is requested, and INIT→RUN otherwise.
- RUN→ARM on a host request or a breakpoint request.
- RUN→HALT on a trace hit.
- ARM→HALT on a latch arrival or a trace hit.
- BOOT_VEC→BOOT_INS on a latch arrival.
- BOOT_INS→HALT on a latch arrival.
- HALT→RUN on the go/exit pulse.

A 16-bit trace counter counts retired instructions. A status vector records every cause that contributed to the current entry. A one-cycle wake pulse brings the core out of a low-power state.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After reset, `halted`, `dbg_enter` and `wake_req` are 0, `halt_cause` is 0 and `trace_count` is 0.
- R2: If `boot_halt_req` is 1 at the first clock after reset release, no instruction executes. `halted` rises in the cycle after the second `latch_valid` pulse, and `halt_cause` bit 4 (reset) is set.
- R3: A host request (`host_dbg_req`) in normal running halts the core in the cycle after the first `latch_valid` strictly later than the request cycle. A latch arrival in the same cycle as the request does not count. `halt_cause` bit 0 (host) is set.
- R4: A latch arrival ends the wait even when it comes with `instr_abort`, because an instruction that will later be aborted still counts.
- R5: A host request while `lowpwr_state` is 1 in normal running gives exactly one `wake_req` pulse in the next cycle. It sets `halt_cause` bits 0 and 1 (low-power), and the halt follows the next latch arrival.
- R6: A retiring breakpoint (`bkpt_retire` with `instr_retire`, no abort) while `force_dbg_en` is 1 halts the core after the next later latch arrival and sets `halt_cause` bit 2. With `force_dbg_en` at 0 the breakpoint has no effect.
- R7: With `trace_en` at 1, each retired, non-aborted instruction decrements a non-zero `trace_count` by one in the next cycle.
- R8: With `trace_en` at 1, retiring a non-aborted instruction while `trace_count` is 0 halts the core in the next cycle and sets `halt_cause` bit 3.
- R9: `instr_abort` (even when it comes with `instr_retire`) neither changes `trace_count` nor causes a trace entry.
- R10: `trace_load` writes `trace_load_val` into `trace_count` in the next cycle. A load takes priority over a retire in the same cycle. `trace_en` is sampled at each retire, and with `trace_en` at 0, retires change nothing.
- R11: Causes that arrive together or while a request is pending produce a single entry. `halt_cause` holds the OR of all of them, and it is non-zero whenever `halted` is 1.
- R12: `halted` holds until `go_exit`. While halted, retire, latch and host events are ignored and `trace_count` is frozen. `go_exit` clears `halted` and `halt_cause` in the next cycle.
- R13: `dbg_enter` is a one-cycle pulse in the first cycle that `halted` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_halt_req | input | 1 | Request to halt right after reset |
| host_dbg_req | input | 1 | Host debug request pulse |
| lowpwr_state | input | 1 | Core is in stop, doze or wait |
| latch_valid | input | 1 | An instruction entered the instruction latch |
| instr_retire | input | 1 | An instruction finished execution |
| instr_abort | input | 1 | An instruction was aborted |
| bkpt_retire | input | 1 | The retiring instruction is a breakpoint |
| force_dbg_en | input | 1 | Breakpoints cause debug entry |
| trace_en | input | 1 | Trace countdown enabled |
| trace_load | input | 1 | Load the trace counter |
| trace_load_val | input | CNT_W | Trace counter load value |
| go_exit | input | 1 | Leave debug mode |
| halted | output | 1 | Core is in debug mode |
| dbg_enter | output | 1 | One-cycle debug-entry event |
| wake_req | output | 1 | One-cycle wake from low power |
| halt_cause | output | 5 | Cause bits: 0 host, 1 low-power, 2 breakpoint, 3 trace, 4 reset |
| trace_count | output | CNT_W | Current trace count |

## Verification
A wrong controller state shows at `halted` within one cycle of the latch arrival or retire that should, or should not, end the wait. A wrong boot sub-state, for example, shifts the halt by one latch pulse. A corrupted cause vector or trace count is visible at once on `halt_cause` or `trace_count`. A missed or repeated wake shows on `wake_req` in the cycle after the request. Comparing all outputs against the reference model on every clock therefore locates most faults to the exact cycle.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
    typedef enum logic [2:0] {
        ST_INIT,
        ST_RUN,
        ST_ARM,
        ST_BOOT_VEC,
        ST_BOOT_INS,
        ST_HALT
    } dbg_state_e;

    localparam int CAUSE_W = 5;
    localparam int C_HOST  = 0;
    localparam int C_LPWR  = 1;
    localparam int C_BKPT  = 2;
    localparam int C_TRACE = 3;
    localparam int C_RESET = 4;
endpackage

// File: rtl/dbg_trace_counter.sv
module dbg_trace_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] count_o,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic             at_zero;

    assign at_zero = (count_q == '0);
    assign hit_o   = step_i && !load_i && at_zero;
    assign count_o = count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_i) begin
            count_q <= load_val_i;
        end else if (step_i && !at_zero) begin
            count_q <= count_q - ONE;
        end
    end

    // R7
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && count_q != '0) |=> (count_q == $past(count_q) - ONE));

    // R10
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_q == $past(load_val_i)));
endmodule

// File: rtl/dbg_cause_collector.sv
module dbg_cause_collector
    import dbg_entry_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] set_i,
    input  logic               clr_i,
    output logic [CAUSE_W-1:0] cause_o
);
    logic [CAUSE_W-1:0] cause_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else if (clr_i) begin
            cause_q <= '0;
        end else begin
            cause_q <= cause_q | set_i;
        end
    end

    assign cause_o = cause_q;

    // R11
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
endmodule

// File: rtl/dbg_entry_fsm.sv
module dbg_entry_fsm
    import dbg_entry_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boot_req_i,
    input  logic               host_req_i,
    input  logic               lowpwr_i,
    input  logic               lat_valid_i,
    input  logic               retire_i,
    input  logic               abort_i,
    input  logic               bkpt_i,
    input  logic               force_en_i,
    input  logic               trace_hit_i,
    input  logic               go_i,
    output logic               exec_ok_o,
    output logic               halted_o,
    output logic               enter_o,
    output logic               wake_o,
    output logic [CAUSE_W-1:0] cause_set_o,
    output logic               cause_clr_o
);
    dbg_state_e         state_q, state_d;
    logic               enter_q, wake_q, wake_d;
    logic               bkpt_fire;
    logic [CAUSE_W-1:0] set_d;
    logic               clr_d;

    assign bkpt_fire = retire_i && bkpt_i && !abort_i && force_en_i;

    // state register and registered pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
            enter_q <= 1'b0;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            enter_q <= (state_d == ST_HALT) && (state_q != ST_HALT);
            wake_q  <= wake_d;
        end
    end

    // next state, cause updates and outputs
    always_comb begin
        state_d = state_q;
        set_d   = '0;
        clr_d   = 1'b0;
        wake_d  = 1'b0;
        unique case (state_q)
            ST_INIT: begin
                if (boot_req_i) begin
                    set_d[C_RESET] = 1'b1;
                    state_d        = ST_BOOT_VEC;
                end else begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (host_req_i) begin
                    set_d[C_HOST] = 1'b1;
                    if (lowpwr_i) begin
                        set_d[C_LPWR] = 1'b1;
                        wake_d        = 1'b1;
                    end
                end
                if (bkpt_fire) set_d[C_BKPT] = 1'b1;
                if (trace_hit_i) begin
                    set_d[C_TRACE] = 1'b1;
                    state_d        = ST_HALT;
                end else if (host_req_i || bkpt_fire) begin
                    state_d = ST_ARM;
                end
            end
            ST_ARM: begin
                if (host_req_i)  set_d[C_HOST]  = 1'b1;
                if (bkpt_fire)   set_d[C_BKPT]  = 1'b1;
                if (trace_hit_i) set_d[C_TRACE] = 1'b1;
                if (trace_hit_i || lat_valid_i) state_d = ST_HALT;
            end
            ST_BOOT_VEC: begin
                if (lat_valid_i) state_d = ST_BOOT_INS;
            end
            ST_BOOT_INS: begin
                if (lat_valid_i) state_d = ST_HALT;
            end
            ST_HALT: begin
                if (go_i) begin
                    clr_d   = 1'b1;
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_INIT;
        endcase
    end

    assign exec_ok_o   = (state_q == ST_RUN) || (state_q == ST_ARM);
    assign halted_o    = (state_q == ST_HALT);
    assign enter_o     = enter_q;
    assign wake_o      = wake_q;
    assign cause_set_o = set_d;
    assign cause_clr_o = clr_d;

    // R5
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |=> !wake_q);

    // R5
    wake_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> $past(host_req_i && lowpwr_i));

    // R13
    enter_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter_q |-> (halted_o && !$past(halted_o)));

    // R12
    go_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && go_i) |=> !halted_o);
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
    import dbg_entry_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boot_halt_req,
    input  logic               host_dbg_req,
    input  logic               lowpwr_state,
    input  logic               latch_valid,
    input  logic               instr_retire,
    input  logic               instr_abort,
    input  logic               bkpt_retire,
    input  logic               force_dbg_en,
    input  logic               trace_en,
    input  logic               trace_load,
    input  logic [CNT_W-1:0]   trace_load_val,
    input  logic               go_exit,
    output logic               halted,
    output logic               dbg_enter,
    output logic               wake_req,
    output logic [CAUSE_W-1:0] halt_cause,
    output logic [CNT_W-1:0]   trace_count
);
    logic               exec_ok;
    logic               trace_step;
    logic               trace_hit;
    logic [CAUSE_W-1:0] cause_set;
    logic               cause_clr;

    assign trace_step = instr_retire && !instr_abort && trace_en && exec_ok;

    dbg_trace_counter #(.CNT_W(CNT_W)) u_trace (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (trace_load),
        .load_val_i (trace_load_val),
        .step_i     (trace_step),
        .count_o    (trace_count),
        .hit_o      (trace_hit)
    );

    dbg_entry_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .boot_req_i  (boot_halt_req),
        .host_req_i  (host_dbg_req),
        .lowpwr_i    (lowpwr_state),
        .lat_valid_i (latch_valid),
        .retire_i    (instr_retire),
        .abort_i     (instr_abort),
        .bkpt_i      (bkpt_retire),
        .force_en_i  (force_dbg_en),
        .trace_hit_i (trace_hit),
        .go_i        (go_exit),
        .exec_ok_o   (exec_ok),
        .halted_o    (halted),
        .enter_o     (dbg_enter),
        .wake_o      (wake_req),
        .cause_set_o (cause_set),
        .cause_clr_o (cause_clr)
    );

    dbg_cause_collector u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (cause_set),
        .clr_i   (cause_clr),
        .cause_o (halt_cause)
    );

    // R11
    cause_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (halt_cause != '0));

    // R9
    abort_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_abort && !trace_load) |=> $stable(trace_count));

    // R12
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !trace_load) |=> $stable(trace_count));
endmodule

// File: tb/tb_dbg_entry_ctrl.sv
module tb_dbg_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_halt_req = 1'b0, host_dbg_req = 1'b0, lowpwr_state = 1'b0;
    logic        latch_valid = 1'b0, instr_retire = 1'b0, instr_abort = 1'b0;
    logic        bkpt_retire = 1'b0, force_dbg_en = 1'b0, trace_en = 1'b0;
    logic        trace_load = 1'b0, go_exit = 1'b0;
    logic [15:0] trace_load_val = '0;
    logic        halted, dbg_enter, wake_req;
    logic [4:0]  halt_cause;
    logic [15:0] trace_count;

    always #2.5 clk = ~clk;

    dbg_entry_ctrl dut (
        .clk(clk), .rst_n(rst_n), .boot_halt_req(boot_halt_req),
        .host_dbg_req(host_dbg_req), .lowpwr_state(lowpwr_state),
        .latch_valid(latch_valid), .instr_retire(instr_retire),
        .instr_abort(instr_abort), .bkpt_retire(bkpt_retire),
        .force_dbg_en(force_dbg_en), .trace_en(trace_en),
        .trace_load(trace_load), .trace_load_val(trace_load_val),
        .go_exit(go_exit), .halted(halted), .dbg_enter(dbg_enter),
        .wake_req(wake_req), .halt_cause(halt_cause), .trace_count(trace_count)
    );

    // reference model: mode 0 init, 1 run, 2 waiting, 3 boot first, 4 boot second, 5 halted
    int         m_mode, m_cnt;
    bit [4:0]   m_cause;
    bit         m_wake, m_enter;
    int         compared = 0, mismatched = 0, cycles = 0;
    string      phase = "R1";
    bit         done = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_cause = '0; m_wake = 0; m_enter = 0;
        end else begin
            bit active, step, hit, bk, go_halt;
            int prev;
            prev    = m_mode;
            active  = (m_mode == 1) || (m_mode == 2);
            step    = active && instr_retire && !instr_abort && trace_en;
            hit     = step && !trace_load && (m_cnt == 0);
            bk      = instr_retire && bkpt_retire && !instr_abort && force_dbg_en;
            m_wake  = 0;
            go_halt = 0;
            if (trace_load) m_cnt = trace_load_val;
            else if (step && m_cnt > 0) m_cnt = m_cnt - 1;
            case (m_mode)
                0: begin
                    if (boot_halt_req) begin m_cause[4] = 1; m_mode = 3; end
                    else m_mode = 1;
                end
                1: begin
                    if (host_dbg_req) begin
                        m_cause[0] = 1;
                        if (lowpwr_state) begin m_cause[1] = 1; m_wake = 1; end
                    end
                    if (bk) m_cause[2] = 1;
                    if (hit) begin m_cause[3] = 1; m_mode = 5; end
                    else if (host_dbg_req || bk) m_mode = 2;
                end
                2: begin
                    if (host_dbg_req) m_cause[0] = 1;
                    if (bk) m_cause[2] = 1;
                    if (hit) m_cause[3] = 1;
                    if (hit || latch_valid) m_mode = 5;
                end
                3: if (latch_valid) m_mode = 4;
                4: if (latch_valid) m_mode = 5;
                5: if (go_exit) begin m_mode = 1; m_cause = '0; end
                default: m_mode = 0;
            endcase
            go_halt = (m_mode == 5) && (prev != 5);
            m_enter = go_halt;
        end
    end

    task automatic cmp(input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", phase, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("halted (R12)",       halted,      (m_mode == 5));
            cmp("dbg_enter (R13)",    dbg_enter,   m_enter);
            cmp("wake_req (R5)",      wake_req,    m_wake);
            cmp("halt_cause (R11)",   halt_cause,  m_cause);
            cmp("trace_count (R7)",   trace_count, m_cnt);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_ev();
        host_dbg_req = 0; latch_valid = 0; instr_retire = 0; instr_abort = 0;
        bkpt_retire = 0; trace_load = 0; go_exit = 0;
    endtask

    task automatic leave_debug();
        go_exit = 1; tick(); go_exit = 0; tick();
    endtask

    initial begin
        // R1 and R2: boot halt after two latch arrivals
        boot_halt_req = 1;
        tick(3);
        rst_n = 1;
        phase = "R1"; tick(); boot_halt_req = 0;
        phase = "R2"; tick(2);
        latch_valid = 1; tick(); latch_valid = 0; tick();
        latch_valid = 1; tick(); latch_valid = 0; tick(2);
        leave_debug();

        // R3: host request, retires in between, then latch arrival
        phase = "R3";
        host_dbg_req = 1; tick(); host_dbg_req = 0;
        instr_retire = 1; tick(2); instr_retire = 0;
        latch_valid = 1; tick(); latch_valid = 0; tick();
        leave_debug();
        // R3: latch in the request cycle does not count
        host_dbg_req = 1; latch_valid = 1; tick(); clear_ev(); tick(2);
        latch_valid = 1; tick(); latch_valid = 0; tick();
        leave_debug();

        // R4: latch arrival paired with abort still ends the wait
        phase = "R4";
        host_dbg_req = 1; tick(); host_dbg_req = 0;
        latch_valid = 1; instr_abort = 1; tick(); clear_ev(); tick();
        leave_debug();

        // R5: host request in low power
        phase = "R5";
        lowpwr_state = 1; tick();
        host_dbg_req = 1; tick(); host_dbg_req = 0; lowpwr_state = 0; tick(2);
        latch_valid = 1; tick(); latch_valid = 0; tick();
        leave_debug();

        // R6: breakpoint ignored without force, honoured with it
        phase = "R6";
        bkpt_retire = 1; instr_retire = 1; tick(); clear_ev();
        latch_valid = 1; tick(); latch_valid = 0; tick(2);
        force_dbg_en = 1;
        bkpt_retire = 1; instr_retire = 1; latch_valid = 1; tick(); clear_ev(); tick();
        latch_valid = 1; tick(); latch_valid = 0; tick();
        leave_debug();
        force_dbg_en = 0;

        // R10: load beats same-cycle retire
        phase = "R10";
        trace_en = 1; trace_load = 1; trace_load_val = 16'd3; instr_retire = 1; tick();
        clear_ev(); tick();

        // R7: countdown
        phase = "R7";
        instr_retire = 1; tick(); instr_retire = 0; tick();
        instr_retire = 1; tick();

        // R9: aborts do not count
        phase = "R9";
        instr_abort = 1; tick(3); instr_retire = 0; tick(2); instr_abort = 0;
        phase = "R7";
        instr_retire = 1; tick(); instr_retire = 0; tick();
        phase = "R9";
        instr_retire = 1; instr_abort = 1; tick(2); clear_ev(); tick();

        // R8: retire at zero enters debug
        phase = "R8";
        instr_retire = 1; tick(); instr_retire = 0; tick(2);
        // R12: events ignored while halted
        phase = "R12";
        instr_retire = 1; latch_valid = 1; host_dbg_req = 1; tick(3); clear_ev(); tick();
        leave_debug();

        // R10: trace disabled means retires do nothing
        phase = "R10";
        trace_en = 0; instr_retire = 1; tick(3); instr_retire = 0;
        trace_load = 1; trace_load_val = 16'd2; tick(); trace_load = 0;
        instr_retire = 1; tick(2); instr_retire = 0; tick();

        // R11: host and trace hit together
        phase = "R11";
        trace_en = 1; trace_load = 1; trace_load_val = 16'd0; tick(); trace_load = 0;
        host_dbg_req = 1; instr_retire = 1; tick(); clear_ev(); tick(2);
        leave_debug();
        // R11: host pending, then breakpoint, then latch
        trace_en = 0; force_dbg_en = 1;
        host_dbg_req = 1; tick(); host_dbg_req = 0;
        bkpt_retire = 1; instr_retire = 1; tick(); clear_ev();
        latch_valid = 1; tick(); latch_valid = 0; tick(2);
        leave_debug();
        force_dbg_en = 0;

        // R1: reset again without boot halt
        phase = "R1";
        rst_n = 0; tick(2); rst_n = 1; tick(3);
        host_dbg_req = 1; tick(); host_dbg_req = 0;
        latch_valid = 1; tick(); latch_valid = 0; tick();
        leave_debug();

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule